// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides its input clock by a ratio that software can change. It uses the pulse-swallow method. A prescaler counts either 17 or 16 input cycles. A swallow count A sets how many prescaler cycles per period run at the longer length. A main count N sets how many prescaler cycles make up one period. The total division is therefore 16·N + A input cycles. Once per period the block raises a single-cycle output pulse. It also drives the prescaler's modulus-control level, so that signal can be observed.

A new setting arrives as one 18-bit word with a one-cycle load strobe. A legal word waits in a pending register. It is applied only when the current period ends, so an output period is never cut short. A word that breaks the ratio rules is rejected, an error flag is raised, and the divider keeps its old ratio. While the run input is low, the divider is halted at the start of a period and emits no pulses. During that time any pending word is applied at once.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While run is high, consecutive output pulses are exactly 16·N + A input cycles apart. N is taken from bits 17:4 of the setting word and A from bits 3:0.
- R2: Every output pulse lasts exactly one clock cycle.
- R3: In each period, the modulus control output is high for the first A prescaler cycles (17·A input cycles) and low for the rest. It rises only at a period boundary.
- R4: A load whose word has N ≤ A, or whose ratio 16·N + A is below 272, sets the illegal flag on the next cycle and leaves the division ratio unchanged.
- R5: A load of a legal word clears the illegal flag on the next cycle.
- R6: A legal word loaded during a period does not change that period. It governs every period that starts after the next boundary.
- R7: While run is low, no pulse is produced. After run goes high, the first pulse appears after exactly 16·N + A clock edges at which run is high. That count uses any word loaded while run was low.
- R8: After reset, pulse, illegal and modulus control are low, and the ratio is 272 (N = 17, A = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: divider counts; low: divider halted at period start |
| load | input | 1 | One-cycle strobe accepting `setting` |
| setting | input | 18 | Division word: N in bits 17:4, A in bits 3:0 |
| pulse | output | 1 | One-cycle pulse per completed period |
| modulus_hi | output | 1 | High while the prescaler divides by 17 |
| illegal | output | 1 | Last loaded word was rejected |

## Verification
The divider is first run with A = 0, so the prescaler never switches to 17. This isolates the main counter from the swallow counter. Settings with A = 15 and the smallest legal N then push the swallow count to its largest value. The ratio 287 against its rejected neighbour 271 tests the edge of the legality rule. Constrained random legal words, each loaded in the middle of a period, separate a correct split between 17-cycles and 16-cycles (seen in the count of modulus-high cycles) from a result that only gets the total right. The same stimulus confirms that the old ratio lasts until the boundary. A halt with a load during idle checks that a restart counts a full new period from the first running edge.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int NW        = 14,
  parameter int AW        = 4,
  parameter int MIN_RATIO = 272,
  parameter int RESET_N   = 17,
  parameter int RESET_A   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [NW+AW-1:0] setting,
  output logic             pulse,
  output logic             modulus_hi,
  output logic             illegal
);
  localparam int WW     = NW + AW;
  localparam int PW     = AW + 1;
  localparam int MOD_LO = 2 ** AW;

  logic [NW-1:0] act_n, pend_n, main_cnt;
  logic [AW-1:0] act_a, pend_a, sw_cnt;
  logic [PW-1:0] pre_cnt;
  logic          pend_v, pulse_q, illegal_q;

  wire [NW-1:0] set_n   = setting[WW-1:AW];
  wire [AW-1:0] set_a   = setting[AW-1:0];
  wire          set_bad = (set_n <= {{(NW-AW){1'b0}}, set_a}) ||
                          (setting < WW'(MIN_RATIO));
  wire          set_ok  = load && !set_bad;

  wire          mod_hi   = (sw_cnt != '0);
  wire [PW-1:0] last_pre = mod_hi ? PW'(MOD_LO) : PW'(MOD_LO - 1);
  wire          tc       = run && (pre_cnt == last_pre);
  wire          wrap     = tc && (main_cnt == NW'(1));
  wire          reload   = !run || wrap;

  wire [NW-1:0] nxt_n = pend_v ? pend_n : act_n;
  wire [AW-1:0] nxt_a = pend_v ? pend_a : act_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_n     <= NW'(RESET_N);
      act_a     <= AW'(RESET_A);
      pend_n    <= '0;
      pend_a    <= '0;
      pend_v    <= 1'b0;
      main_cnt  <= NW'(RESET_N);
      sw_cnt    <= AW'(RESET_A);
      pre_cnt   <= '0;
      pulse_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (load) illegal_q <= set_bad;
      if (set_ok) begin
        pend_n <= set_n;
        pend_a <= set_a;
      end
      if (set_ok) pend_v <= 1'b1;
      else if (reload) pend_v <= 1'b0;
      if (reload) begin
        act_n    <= nxt_n;
        act_a    <= nxt_a;
        main_cnt <= nxt_n;
        sw_cnt   <= nxt_a;
        pre_cnt  <= '0;
      end else if (tc) begin
        pre_cnt  <= '0;
        main_cnt <= main_cnt - NW'(1);
        if (mod_hi) sw_cnt <= sw_cnt - AW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end

  assign pulse      = pulse_q;
  assign modulus_hi = mod_hi;
  assign illegal    = illegal_q;
endmodule

// File: rtl/pulse_swallow_divider_sva.sv
module pulse_swallow_divider_sva #(
  parameter int NW        = 14,
  parameter int AW        = 4,
  parameter int MIN_RATIO = 272
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load,
  input logic [NW+AW-1:0] setting,
  input logic             pulse,
  input logic             modulus_hi,
  input logic             illegal
);
  localparam int WW = NW + AW;

  wire word_bad = (setting[WW-1:AW] <= {{(NW-AW){1'b0}}, setting[AW-1:0]}) ||
                  (setting < WW'(MIN_RATIO));

  logic [WW:0] gap;
  logic        seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (!run) seen <= 1'b0;
      else if (pulse) seen <= 1'b1;
      if (pulse) gap <= (WW+1)'(1);
      else if (gap != '1) gap <= gap + (WW+1)'(1);
    end
  end

  p_min_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && seen && run) |-> (gap >= (WW+1)'(MIN_RATIO)));
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  p_mod_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $rose(modulus_hi)) |-> pulse);
  p_bad_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_bad) |=> illegal);
  p_good_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !word_bad) |=> !illegal);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pulse);
endmodule

bind pulse_swallow_divider pulse_swallow_divider_sva #(
  .NW(NW), .AW(AW), .MIN_RATIO(MIN_RATIO)
) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .load(load), .setting(setting),
  .pulse(pulse), .modulus_hi(modulus_hi), .illegal(illegal)
);

// File: tb/pulse_swallow_divider_bench.sv
`timescale 1ns/1ps
module pulse_swallow_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        load = 1'b0;
  logic [17:0] setting = '0;
  logic        pulse, modulus_hi, illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .setting(setting),
    .pulse(pulse), .modulus_hi(modulus_hi), .illegal(illegal)
  );

  function automatic int ratio_of(logic [17:0] w);
    return 16 * int'(w[17:4]) + int'(w[3:0]);
  endfunction

  function automatic bit legal_of(logic [17:0] w);
    return (int'(w[17:4]) > int'(w[3:0])) && (ratio_of(w) >= 272);
  endfunction

  function automatic logic [17:0] mk(int n, int a);
    return {14'(n), 4'(a)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at a negedge with pulse high; returns at the next pulse-high negedge.
  task automatic measure(int exp_r, int exp_a, string req, bit do_load, logic [17:0] w);
    int n = 1;
    int mh = modulus_hi ? 1 : 0;
    if (do_load) begin
      load = 1'b1;
      setting = w;
    end
    @(negedge clk);
    load = 1'b0;
    check(pulse == 1'b0, "R2 pulse width", int'(pulse), 0);
    while (!pulse && n < 270000) begin
      n++;
      mh += modulus_hi ? 1 : 0;
      @(negedge clk);
    end
    check(n == exp_r, req, n, exp_r);
    check(mh == 17 * exp_a, "R3 modulus-high cycles", mh, 17 * exp_a);
  endtask

  initial begin
    int cnt;
    int cur_r, cur_a;
    logic [17:0] w;
    bit quiet;
    void'($urandom(32'h5A17_0C3D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse == 1'b0, "R8 reset pulse", int'(pulse), 0);
    check(illegal == 1'b0, "R8 reset illegal", int'(illegal), 0);
    check(modulus_hi == 1'b0, "R8 reset modulus", int'(modulus_hi), 0);

    run = 1'b1;
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end while (!pulse && cnt < 270000);
    check(cnt == 272, "R8 default ratio first pulse", cnt, 272);

    w = mk(40, 7);
    measure(272, 0, "R6 period keeps old ratio", 1'b1, w);
    check(illegal == 1'b0, "R5 legal load flag", int'(illegal), 0);
    measure(647, 7, "R1 ratio N=40 A=7", 1'b0, '0);

    measure(647, 7, "R1 ratio N=40 A=7", 1'b1, mk(16, 15));
    check(illegal == 1'b1, "R4 ratio 271 rejected flag", int'(illegal), 1);
    measure(647, 7, "R4 ratio kept after 271", 1'b1, mk(5, 9));
    check(illegal == 1'b1, "R4 N<=A rejected flag", int'(illegal), 1);
    measure(647, 7, "R4 ratio kept after N<=A", 1'b1, mk(17, 15));
    check(illegal == 1'b0, "R5 flag cleared", int'(illegal), 0);
    measure(287, 15, "R1 ratio 287 N=17 A=15", 1'b1, mk(17, 0));
    measure(272, 0, "R1 minimum ratio 272", 1'b0, '0);
    cur_r = 272;
    cur_a = 0;

    for (int i = 0; i < 12; i++) begin
      int n = 17 + int'($urandom_range(0, 110));
      int a = int'($urandom_range(0, 15));
      w = mk(n, a);
      if (!legal_of(w)) w = mk(17, a);
      measure(cur_r, cur_a, "R6 old ratio before boundary", 1'b1, w);
      cur_r = ratio_of(w);
      cur_a = int'(w[3:0]);
      measure(cur_r, cur_a, "R1 random ratio", 1'b0, '0);
    end

    run = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i == 100) begin
        load = 1'b1;
        setting = mk(30, 3);
      end else begin
        load = 1'b0;
      end
      if (pulse) quiet = 1'b0;
    end
    check(quiet, "R7 no pulse while halted", int'(quiet), 1);
    run = 1'b1;
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end while (!pulse && cnt < 270000);
    check(cnt == 483, "R7 restart with idle-loaded word", cnt, 483);
    measure(483, 3, "R1 ratio N=30 A=3", 1'b0, '0);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule